// File: doc/BRIEF.md
# Daisy-Chain Control Word Router

This block sits behind the serial receiver of a converter front end that may be one link in a chain of up to eight identical devices. Each received 16-bit word is classified against the current operating mode. A word that is a control word is either taken locally, when its 3-bit device address is zero, or passed on with that address reduced by one, so that the next device in the chain (or the host at the end of the loop) sees it. The block emits exactly one 16-bit word for every word it receives, one clock later.

Three operating modes are kept in a small state machine that holds the two mode bits of control register 0. In program mode every word is a control word. In mixed mode only words whose top bit is set are control words, and the rest are treated as data and ignored. In plain data mode every incoming word is ignored, which makes that mode final until reset. Local register writes leave the block through a one-cycle write strobe with index and data. The locally produced output word is `{0, chain_pos, sample_in}` in data and mixed mode, and zero in program mode.

Top module: `ccr_router`

## Requirements
- R1: While and directly after reset, `out_valid` and `reg_wr_en` are 0 and `mode` reads 0 (program).
- R2: Every cycle with `in_valid` high produces `out_valid` high exactly one clock later, and a cycle without `in_valid` produces no output, including back-to-back words.
- R3: A control word whose address field (bits 14:12) is non-zero is output with that field decremented by one and all other bits unchanged, and causes no register write.
- R4: A control word with address zero writes register index bits 11:8 with data bits 7:0 through the write port, one clock after it is received. In program mode the output word is then 16'h0000.
- R5: A control word addressed to this device whose register index is not below the number of implemented registers (default 6) produces no write strobe.
- R6: A local write to register index 0 sets the mode: data bit 0 = 0 gives program (`mode`=0), bit 0 = 1 with bit 1 = 0 gives data (`mode`=1), and both bits set give mixed (`mode`=2). The mode changes only through such a write.
- R7: In data mode no word causes a write or a forward, the output is the local word `{0, chain_pos, sample_in}`, and the mode stays data until reset.
- R8: In mixed mode a word with bit 15 = 1 is handled as a control word. A word with bit 15 = 0 is ignored, and the local output word has bit 15 = 0.
- R9: Mixed mode can be entered with the first word after reset, by writing register 0 with no earlier setup. In program mode bit 15 of the incoming word is not examined.
- R10: Asserting reset while in data mode returns the block to program mode, where writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chain_pos | input | 3 | Hardwired position of this device in the chain |
| sample_in | input | 12 | Current conversion result placed in local output words |
| in_valid | input | 1 | Strobe: `in_word` holds a received word |
| in_word | input | 16 | Received word |
| out_valid | output | 1 | Strobe: `out_word` holds an outgoing word |
| out_word | output | 16 | Forwarded control word or local output word |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_idx | output | 4 | Register index of the write |
| reg_wr_data | output | 8 | Register data of the write |
| mode | output | 2 | Current mode: 0 program, 1 data, 2 mixed |

## Verification
A wrong mode state appears at the ports on the next word. Program mode outputs zero instead of `{0, chain_pos, sample}`, and data mode suppresses writes and forwards that mixed mode would perform. A faulty address decode or decrement shows in the very next output word, or as a write strobe that is missing or should not be there. Because each input maps to one output one clock later, a wrong count or timing is visible as an `out_valid` pulse that is missing or extra in the cycle after the word.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 3;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 8;
    localparam int SMP_W  = WORD_W - 1 - ADDR_W;

    typedef enum logic [1:0] {
        MODE_PROG  = 2'd0,
        MODE_DATA  = 2'd1,
        MODE_MIXED = 2'd2
    } mode_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              wr_en;
        logic [IDX_W-1:0]  wr_idx;
        logic [DATA_W-1:0] wr_data;
    } out_s;

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input  mode_e             mode,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [ADDR_W-1:0] chain_pos,
    input  logic [SMP_W-1:0]  sample_in,
    output out_s              nxt_d
);

    localparam int             ADDR_LSB  = WORD_W - 1 - ADDR_W;
    localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W+1)'(NUM_REGS);

    logic              flag;
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] dat;
    logic              is_ctrl;
    logic              for_me;
    logic              idx_ok;
    logic [WORD_W-1:0] local_word;
    logic [WORD_W-1:0] fwd_word;

    always_comb begin
        flag   = in_word[WORD_W-1];
        addr   = in_word[ADDR_LSB +: ADDR_W];
        idx    = in_word[DATA_W +: IDX_W];
        dat    = in_word[DATA_W-1:0];

        // which words count as control in each mode
        case (mode)
            MODE_PROG:  is_ctrl = 1'b1;
            MODE_MIXED: is_ctrl = flag;
            default:    is_ctrl = 1'b0;
        endcase

        for_me = (addr == '0);
        idx_ok = ({1'b0, idx} < IDX_LIMIT);

        local_word = (mode == MODE_PROG) ? '0 : {1'b0, chain_pos, sample_in};
        fwd_word   = {flag, addr - ADDR_W'(1), in_word[ADDR_LSB-1:0]};

        nxt_d = '0;
        if (in_valid) begin
            nxt_d.vld  = 1'b1;
            nxt_d.word = (is_ctrl && !for_me) ? fwd_word : local_word;
            if (is_ctrl && for_me && idx_ok) begin
                nxt_d.wr_en   = 1'b1;
                nxt_d.wr_idx  = idx;
                nxt_d.wr_data = dat;
            end
        end
    end

endmodule

// File: rtl/ccr_mode_fsm.sv
module ccr_mode_fsm
    import ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_bits,
    output mode_e            mode_q
);

    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wr_en && (wr_idx == '0) && (mode_q != MODE_DATA)) begin
            if (!wr_bits[0])
                mode_d = MODE_PROG;
            else if (wr_bits[1])
                mode_d = MODE_MIXED;
            else
                mode_d = MODE_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_PROG;
        else
            mode_q <= mode_d;
    end

    AST_DATA_IS_FINAL: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DATA) |=> (mode_q == MODE_DATA)); // R7

    AST_MODE_NEEDS_REG0_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_idx == '0)) |=> $stable(mode_q)); // R6

endmodule

// File: rtl/ccr_router.sv
module ccr_router
    import ccr_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] chain_pos,
    input  logic [SMP_W-1:0]  sample_in,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              reg_wr_en,
    output logic [IDX_W-1:0]  reg_wr_idx,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [1:0]        mode
);

    localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W+1)'(NUM_REGS);

    mode_e mode_q;
    out_s  nxt_d;
    out_s  out_q;

    ccr_decode #(.NUM_REGS(NUM_REGS)) u_decode (
        .mode      (mode_q),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .chain_pos (chain_pos),
        .sample_in (sample_in),
        .nxt_d     (nxt_d)
    );

    ccr_mode_fsm u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (nxt_d.wr_en),
        .wr_idx  (nxt_d.wr_idx),
        .wr_bits (nxt_d.wr_data[1:0]),
        .mode_q  (mode_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= nxt_d;
    end

    assign out_valid   = out_q.vld;
    assign out_word    = out_q.word;
    assign reg_wr_en   = out_q.wr_en;
    assign reg_wr_idx  = out_q.wr_idx;
    assign reg_wr_data = out_q.wr_data;
    assign mode        = mode_q;

    AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2

    AST_WR_WITH_OUT: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> out_valid); // R4

    AST_WR_IDX_IMPLEMENTED: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> ({1'b0, reg_wr_idx} < IDX_LIMIT)); // R5

    AST_DATA_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == MODE_DATA) && $past(mode_q == MODE_DATA)) |-> !reg_wr_en); // R7

    AST_MIXED_LOCAL_MSB: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mode_q == MODE_MIXED) && !in_word[WORD_W-1])
        |=> !out_word[WORD_W-1]); // R8

endmodule

// File: tb/ccr_router_tb.sv
module ccr_router_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  chain_pos = 3'd5;
    logic [11:0] sample_in = 12'hABC;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_valid;
    logic [15:0] out_word;
    logic        reg_wr_en;
    logic [3:0]  reg_wr_idx;
    logic [7:0]  reg_wr_data;
    logic [1:0]  mode;

    int errors = 0;
    int checks = 0;

    localparam logic [15:0] LOCAL_W = 16'h5ABC;

    always #2.5 clk = ~clk;

    ccr_router u_dut (
        .clk(clk), .rst(rst), .chain_pos(chain_pos), .sample_in(sample_in),
        .in_valid(in_valid), .in_word(in_word), .out_valid(out_valid),
        .out_word(out_word), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
        .reg_wr_data(reg_wr_data), .mode(mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // drive one word, return at the negedge one clock after capture
    task automatic xfer(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 out_valid", {31'b0, out_valid}, 0);
        chk("R1 wr_en", {31'b0, reg_wr_en}, 0);
        chk("R1 mode", {30'b0, mode}, 0);
    endtask

    task automatic t_forward();
        xfer(16'h3A55);
        chk("R3 fwd word a3", {16'b0, out_word}, 32'h2A55);
        chk("R3 no write a3", {31'b0, reg_wr_en}, 0);
        xfer(16'hF123);
        chk("R3 fwd word a7 flag", {16'b0, out_word}, 32'hE123);
        xfer(16'h1ABC);
        chk("R3 fwd word a1", {16'b0, out_word}, 32'h0ABC);
        chk("R2 out_valid", {31'b0, out_valid}, 1);
    endtask

    task automatic t_prog_write();
        xfer(16'h0207);
        chk("R4 wr_en", {31'b0, reg_wr_en}, 1);
        chk("R4 wr_idx", {28'b0, reg_wr_idx}, 2);
        chk("R4 wr_data", {24'b0, reg_wr_data}, 32'h07);
        chk("R4 prog out word", {16'b0, out_word}, 0);
        chk("R4 mode unchanged", {30'b0, mode}, 0);
        xfer(16'h0955);
        chk("R5 idx9 no write", {31'b0, reg_wr_en}, 0);
        xfer(16'h0677);
        chk("R5 idx6 no write", {31'b0, reg_wr_en}, 0);
        xfer(16'h0599);
        chk("R5 idx5 written", {31'b0, reg_wr_en}, 1);
    endtask

    task automatic t_stream();
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 16'h2111;
        @(negedge clk);
        chk("R2 b2b first", {15'b0, out_valid, out_word}, {15'b0, 1'b1, 16'h1111});
        in_word = 16'h0312;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b second", {15'b0, out_valid, out_word}, {15'b0, 1'b1, 16'h0000});
        chk("R2 b2b second write", {31'b0, reg_wr_en}, 1);
        @(negedge clk);
        chk("R2 idle no out", {31'b0, out_valid}, 0);
    endtask

    task automatic t_data_mode();
        xfer(16'h0001);
        chk("R6 enter data", {30'b0, mode}, 1);
        xfer(16'h0103);
        chk("R7 no write", {31'b0, reg_wr_en}, 0);
        chk("R7 local word", {16'b0, out_word}, {16'b0, LOCAL_W});
        xfer(16'h3000);
        chk("R7 no forward", {16'b0, out_word}, {16'b0, LOCAL_W});
        xfer(16'h8003);
        chk("R7 flag ignored", {31'b0, reg_wr_en}, 0);
        chk("R7 mode stays", {30'b0, mode}, 1);
        do_reset();
        chk("R10 mode after reset", {30'b0, mode}, 0);
        xfer(16'h0244);
        chk("R10 write accepted", {31'b0, reg_wr_en}, 1);
    endtask

    task automatic t_mixed();
        do_reset();
        xfer(16'h8003);
        chk("R9 first write mixed", {30'b0, mode}, 2);
        chk("R9 out prog word", {16'b0, out_word}, 0);
        xfer(16'h8145);
        chk("R8 ctrl write", {19'b0, reg_wr_en, reg_wr_idx, reg_wr_data}, {19'b0, 1'b1, 4'd1, 8'h45});
        chk("R8 local msb 0", {16'b0, out_word}, {16'b0, LOCAL_W});
        sample_in = 12'h123;
        xfer(16'h1145);
        chk("R8 data word ignored", {31'b0, reg_wr_en}, 0);
        chk("R8 data word local", {16'b0, out_word}, 32'h5123);
        xfer(16'h9145);
        chk("R8 ctrl forward", {16'b0, out_word}, 32'h8145);
        xfer(16'h8000);
        chk("R6 back to prog", {30'b0, mode}, 0);
        do_reset();
        xfer(16'h0003);
        chk("R9 flag not needed", {30'b0, mode}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        @(negedge clk);
        t_reset();
        t_forward();
        t_prog_write();
        t_stream();
        t_data_mode();
        t_mixed();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule